// File: doc/BRIEF.md
# Interrupt Controller Mode Register

This block keeps the one control word that decides how a local interrupt controller is reached and in which mode it runs. The word holds a page-aligned base address for the memory-mapped register window, a processor-role bit, and two mode bits. Software writes a whole new word through a single write port. The block checks the word against the reserved-bit rules and a table of legal mode moves. It then either commits the word or drops it and raises a one-cycle fault pulse, which the surrounding core turns into an exception.

The rest of the controller sees the current mode on `mode_o`, together with a feature-present flag. When a committed write changes the mode, the block issues a one-cycle `ctl_reset_req`, so the controller state behind it goes back to its defaults, including the identifier. The block also gates the memory window. An access hits only in legacy mode, and only when its page number equals the stored base. Otherwise reads return all ones and writes are suppressed.

Top module: `imcr_mode_reg`

## Requirements
- R1: After reset the word reads 64'h0000_0000_FEE0_0900: base page 24'hFEE00 in bits [35:12], role bit 8 set, enable bit 11 set, extended bit 10 clear. The block is in legacy mode, and fault and reset request are low.
- R2: `mode_o` is {bit10, bit11} of the stored word: 2'b00 disabled, 2'b01 legacy, 2'b11 extended. `feature_o` equals the stored enable bit 11, so it is clear when disabled.
- R3: A write with bit 10 set and bit 11 clear faults from every mode.
- R4: In extended mode, a write that selects legacy faults and a write that selects disabled commits.
- R5: In disabled mode, a write that selects extended faults and a write that selects legacy commits.
- R6: In legacy mode, a write that selects extended commits.
- R7: A write faults if any reserved bit is set. The reserved bits are bits [7:0], bit 9, and every bit at or above PA_W (36 by default).
- R8: A faulting write leaves the whole word unchanged. `wr_fault` is high for exactly the one cycle after the write edge, and never together with a reset request.
- R9: A committed write that changes the mode pulses `ctl_reset_req` for one cycle after the write edge. A committed write that keeps the mode and changes only the base or role bit raises no reset request.
- R10: `win_hit` is high only in legacy mode, and only when `win_page` equals the stored base page. After a base change, the window answers at the new page. On a hit, `win_rd_out` passes `win_rd_in` and `win_wr_out` follows `win_wr_in`.
- R11: When `win_hit` is low, `win_rd_out` is all ones and `win_wr_out` is low. This is the case in disabled mode, in extended mode, and on any other page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, one per cycle it is high |
| wr_data | input | 64 | Proposed control word |
| reg_value | output | 64 | Stored control word |
| wr_fault | output | 1 | Pulse: last write was rejected |
| mode_o | output | 2 | Current mode {extended, enable} |
| ctl_reset_req | output | 1 | Pulse: controller state must return to defaults |
| feature_o | output | 1 | Controller-present flag |
| win_page | input | 24 | Page number of a window access |
| win_rd_in | input | 32 | Read data from the registers behind the window |
| win_wr_in | input | 1 | Write strobe of a window access |
| win_rd_out | output | 32 | Read data returned to the access |
| win_wr_out | output | 1 | Write strobe passed to the registers behind the window |
| win_hit | output | 1 | Access falls in the enabled window |

## Verification
A wrong stored word shows up in `reg_value` and `mode_o` one cycle after the write edge that caused it. It shows up in `win_hit` and `win_rd_out` in that same cycle, so a per-cycle reference comparison catches it at once. A wrong decision in the legality table shows up as a missing or spurious `wr_fault`, and also as a mode that changed or did not. A reset request that is lost or extra shows up on `ctl_reset_req` in the single cycle after the write. The stimulus therefore walks every edge of the mode graph, both legal and illegal, and includes same-mode relocations.

// File: rtl/imcr_pkg.sv
package imcr_pkg;

  localparam int ROLE_BIT = 8;
  localparam int EXT_BIT  = 10;
  localparam int EN_BIT   = 11;

  // Mode code is {extended, enable}; 2'b10 is never a legal state.
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_BAD    = 2'b10,
    MODE_EXT    = 2'b11
  } imcr_mode_e;

  // Legal mode moves: disabled <-> legacy, legacy -> extended, extended -> disabled.
  function automatic logic move_ok(imcr_mode_e from_m, imcr_mode_e to_m);
    logic ok;
    ok = 1'b0;
    unique case (from_m)
      MODE_OFF:    ok = (to_m == MODE_OFF) || (to_m == MODE_LEGACY);
      MODE_LEGACY: ok = (to_m != MODE_BAD);
      MODE_EXT:    ok = (to_m == MODE_OFF) || (to_m == MODE_EXT);
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/imcr_wr_check.sv
module imcr_wr_check
  import imcr_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int PA_W    = 36,
  parameter int PAGE_W  = 12
) (
  input  imcr_mode_e          cur_mode,
  input  logic [WORD_W-1:0]   wr_data,
  output logic                accept,
  output logic                mode_change
);

  localparam logic [WORD_W-1:0] ONE       = WORD_W'(1);
  localparam logic [WORD_W-1:0] BASE_MASK = ((ONE << PA_W) - ONE) & ~((ONE << PAGE_W) - ONE);
  localparam logic [WORD_W-1:0] CTRL_MASK = (ONE << ROLE_BIT) | (ONE << EXT_BIT) | (ONE << EN_BIT);
  localparam logic [WORD_W-1:0] DEF_MASK  = BASE_MASK | CTRL_MASK;

  imcr_mode_e req_mode;
  logic       rsvd_hit;

  always_comb begin
    req_mode    = imcr_mode_e'({wr_data[EXT_BIT], wr_data[EN_BIT]});
    rsvd_hit    = |(wr_data & ~DEF_MASK);
    accept      = !rsvd_hit && move_ok(cur_mode, req_mode);
    mode_change = (req_mode != cur_mode);
  end

endmodule

// File: rtl/imcr_window.sv
module imcr_window
  import imcr_pkg::*;
#(
  parameter int PG_W   = 24,
  parameter int DATA_W = 32
) (
  input  imcr_mode_e          cur_mode,
  input  logic [PG_W-1:0]     base_page,
  input  logic [PG_W-1:0]     acc_page,
  input  logic [DATA_W-1:0]   rd_in,
  input  logic                wr_in,
  output logic [DATA_W-1:0]   rd_out,
  output logic                wr_out,
  output logic                hit
);

  always_comb begin
    hit    = (cur_mode == MODE_LEGACY) && (acc_page == base_page);
    rd_out = hit ? rd_in : {DATA_W{1'b1}};
    wr_out = wr_in && hit;
  end

endmodule

// File: rtl/imcr_mode_reg.sv
module imcr_mode_reg
  import imcr_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int PA_W    = 36,
  parameter int PAGE_W  = 12,
  parameter int DATA_W  = 32,
  parameter logic [PA_W-PAGE_W-1:0] RESET_BASE = 24'hFEE00,
  parameter logic RESET_ROLE = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [WORD_W-1:0]        reg_value,
  output logic                     wr_fault,
  output logic [1:0]               mode_o,
  output logic                     ctl_reset_req,
  output logic                     feature_o,
  input  logic [PA_W-PAGE_W-1:0]   win_page,
  input  logic [DATA_W-1:0]        win_rd_in,
  input  logic                     win_wr_in,
  output logic [DATA_W-1:0]        win_rd_out,
  output logic                     win_wr_out,
  output logic                     win_hit
);

  localparam int PG_W = PA_W - PAGE_W;
  localparam logic [WORD_W-1:0] RESET_WORD =
      (WORD_W'(RESET_BASE) << PAGE_W) |
      (WORD_W'(RESET_ROLE) << ROLE_BIT) |
      (WORD_W'(1) << EN_BIT);

  logic [WORD_W-1:0] word_q;
  logic              fault_q, fault_d;
  logic              rreq_q,  rreq_d;
  logic              load_en;
  logic              accept, mode_change;
  imcr_mode_e        cur_mode;

  assign cur_mode = imcr_mode_e'({word_q[EXT_BIT], word_q[EN_BIT]});

  imcr_wr_check #(
    .WORD_W (WORD_W),
    .PA_W   (PA_W),
    .PAGE_W (PAGE_W)
  ) u_check (
    .cur_mode    (cur_mode),
    .wr_data     (wr_data),
    .accept      (accept),
    .mode_change (mode_change)
  );

  // Next-state decision
  always_comb begin
    load_en = wr_en && accept;
    fault_d = wr_en && !accept;
    rreq_d  = load_en && mode_change;
  end

  // Stored word, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RESET_WORD;
    end else if (load_en) begin
      word_q <= wr_data;
    end
  end

  // Pulse outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      fault_q <= fault_d;
      rreq_q  <= rreq_d;
    end
  end

  imcr_window #(
    .PG_W   (PG_W),
    .DATA_W (DATA_W)
  ) u_window (
    .cur_mode  (cur_mode),
    .base_page (word_q[PA_W-1:PAGE_W]),
    .acc_page  (win_page),
    .rd_in     (win_rd_in),
    .wr_in     (win_wr_in),
    .rd_out    (win_rd_out),
    .wr_out    (win_wr_out),
    .hit       (win_hit)
  );

  assign reg_value     = word_q;
  assign wr_fault      = fault_q;
  assign ctl_reset_req = rreq_q;
  assign mode_o        = cur_mode;
  assign feature_o     = word_q[EN_BIT];

endmodule

// File: rtl/imcr_mode_reg_sva.sv
module imcr_mode_reg_sva #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] reg_value,
  input logic              wr_fault,
  input logic [1:0]        mode_o,
  input logic              ctl_reset_req,
  input logic              win_hit
);

  AST_FAULT_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> reg_value == $past(reg_value)); // R8

  AST_FAULT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fault && !wr_en) |=> !wr_fault); // R8

  AST_FAULT_NOT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fault && ctl_reset_req)); // R8

  AST_NO_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b10); // R3

  AST_EXT_NOT_TO_LEGACY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 2'b11) |-> mode_o != 2'b01); // R4

  AST_OFF_NOT_TO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 2'b00) |-> mode_o != 2'b11); // R5

  AST_RESET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != $past(mode_o)) |-> ctl_reset_req); // R9

  AST_RESET_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_req |-> mode_o != $past(mode_o)); // R9

  AST_WINDOW_LEGACY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> mode_o == 2'b01); // R10

endmodule

bind imcr_mode_reg imcr_mode_reg_sva #(.WORD_W(WORD_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .reg_value     (reg_value),
  .wr_fault      (wr_fault),
  .mode_o        (mode_o),
  .ctl_reset_req (ctl_reset_req),
  .win_hit       (win_hit)
);

// File: tb/imcr_mode_reg_test.sv
`timescale 1ns/1ps
module imcr_mode_reg_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] reg_value;
  logic        wr_fault, ctl_reset_req, feature_o;
  logic [1:0]  mode_o;
  logic [23:0] win_page = '0;
  logic [31:0] win_rd_in = 32'h1234_5678;
  logic        win_wr_in = 1'b0;
  logic [31:0] win_rd_out;
  logic        win_wr_out, win_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  imcr_mode_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .reg_value(reg_value), .wr_fault(wr_fault), .mode_o(mode_o),
    .ctl_reset_req(ctl_reset_req), .feature_o(feature_o),
    .win_page(win_page), .win_rd_in(win_rd_in), .win_wr_in(win_wr_in),
    .win_rd_out(win_rd_out), .win_wr_out(win_wr_out), .win_hit(win_hit)
  );

  // Behavioural reference model
  logic [63:0] m_word;
  logic        m_fault, m_rreq;

  function automatic bit legal_word(logic [63:0] old_w, logic [63:0] new_w);
    int om, nm;
    if (new_w[7:0] != 0 || new_w[9] || new_w[63:36] != 0) return 0;
    om = new_w[11] ? 0 : 0; // placeholder cleared below
    om = old_w[11] ? (old_w[10] ? 2 : 1) : 0;
    if (new_w[10] && !new_w[11]) return 0;
    nm = new_w[11] ? (new_w[10] ? 2 : 1) : 0;
    if (om == 0 && nm == 2) return 0;
    if (om == 2 && nm == 1) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_word  = 64'h0000_0000_FEE0_0900;
      m_fault = 0;
      m_rreq  = 0;
    end else begin
      m_fault = 0;
      m_rreq  = 0;
      if (wr_en) begin
        if (legal_word(m_word, wr_data)) begin
          m_rreq = (wr_data[11:10] != m_word[11:10]);
          m_word = wr_data;
        end else begin
          m_fault = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit m_hit;
      m_hit = (m_word[11:10] == 2'b10) && (win_page == m_word[35:12]);
      chk("R8 word", reg_value, m_word);
      chk("R8 fault", {63'd0, wr_fault}, {63'd0, m_fault});
      chk("R9 reset req", {63'd0, ctl_reset_req}, {63'd0, m_rreq});
      chk("R2 mode", {62'd0, mode_o}, {62'd0, m_word[10], m_word[11]});
      chk("R2 feature", {63'd0, feature_o}, {63'd0, m_word[11]});
      chk("R10 hit", {63'd0, win_hit}, {63'd0, m_hit});
      chk("R11 rd", {32'd0, win_rd_out}, {32'd0, m_hit ? win_rd_in : 32'hFFFF_FFFF});
      chk("R11 wr", {63'd0, win_wr_out}, {63'd0, win_wr_in && m_hit});
    end
  end

  task automatic wr(input logic [63:0] d, input bit exp_fault, input bit exp_rreq, input string tag);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk({tag, " fault"}, {63'd0, wr_fault}, {63'd0, exp_fault});
    chk({tag, " reset req"}, {63'd0, ctl_reset_req}, {63'd0, exp_rreq});
  endtask

  task automatic probe(input logic [23:0] pg, input bit exp_hit, input string tag);
    @(posedge clk); #1;
    win_page = pg; win_wr_in = 1'b1;
    #2;
    chk({tag, " hit"}, {63'd0, win_hit}, {63'd0, exp_hit});
    chk({tag, " rdata"}, {32'd0, win_rd_out}, {32'd0, exp_hit ? win_rd_in : 32'hFFFF_FFFF});
    chk({tag, " wstrobe"}, {63'd0, win_wr_out}, {63'd0, exp_hit});
    win_wr_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset word", reg_value, 64'h0000_0000_FEE0_0900);
    chk("R1 reset mode", {62'd0, mode_o}, 64'd1);
    chk("R1 fault low", {63'd0, wr_fault}, 64'd0);

    probe(24'hFEE00, 1'b1, "R10 legacy base");
    probe(24'hFEE01, 1'b0, "R11 other page");

    wr(64'h0000_0000_FEE0_0901, 1, 0, "R7 bit0");
    wr(64'h0000_0000_FEE0_0B00, 1, 0, "R7 bit9");
    wr(64'h0000_0010_FEE0_0900, 1, 0, "R7 bit36");
    chk("R8 word kept", reg_value, 64'h0000_0000_FEE0_0900);
    wr(64'h0000_0000_FEE0_0500, 1, 0, "R3 from legacy");

    wr(64'h0000_0000_FED4_0900, 0, 0, "R9 relocate");
    probe(24'hFED40, 1'b1, "R10 new base");
    probe(24'hFEE00, 1'b0, "R11 old base");
    wr(64'h0000_0000_FED4_0800, 0, 0, "R9 role clear");

    wr(64'h0000_0000_FED4_0C00, 0, 1, "R6 legacy to ext");
    probe(24'hFED40, 1'b0, "R11 ext mode");
    wr(64'h0000_0000_FED4_0800, 1, 0, "R4 ext to legacy");
    wr(64'h0000_0000_FED4_0400, 1, 0, "R3 from ext");
    chk("R8 ext kept", reg_value, 64'h0000_0000_FED4_0C00);
    wr(64'h0000_0000_FED4_0000, 0, 1, "R4 ext to off");
    @(negedge clk);
    chk("R2 feature off", {63'd0, feature_o}, 64'd0);
    probe(24'hFED40, 1'b0, "R11 off mode");

    wr(64'h0000_0000_FED4_0C00, 1, 0, "R5 off to ext");
    wr(64'h0000_0000_FED4_0400, 1, 0, "R3 from off");
    wr(64'h0000_0000_FEE0_0900, 0, 1, "R5 off to legacy");
    probe(24'hFEE00, 1'b1, "R10 legacy again");

    // back-to-back: faulting write followed by a committed one
    wr(64'h0000_0000_FEE0_0C01, 1, 0, "R7 back to back");
    wr(64'h0000_0000_FEE0_0C00, 0, 1, "R6 after fault");
    @(negedge clk);
    chk("R8 pulse ended", {63'd0, wr_fault}, 64'd0);

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule